// File: doc/BRIEF.md
# Second-Operand Shifter

This block shifts the second source operand of an ALU before the arithmetic or logic operation uses it. The first operand never passes through it. It is purely combinational. It takes a data word, a shift-kind code, an immediate shift distance and the current carry flag. It returns the shifted word and a carry bit that the flag logic can take in place of the ALU carry when a logical operation updates the flags.

Five kinds are supported: logical left, logical right, arithmetic right, rotate right, and a single-position rotate right through the carry flag. An arithmetic left shift is not a separate kind, because it is the same as a logical left shift. In the carry rotate, the carry flag acts as a bit sitting above the top data bit. The distance is a 5-bit immediate, so distances larger than 31 cannot occur.

Top module: `operand_shifter`

## Requirements
- R1: Kind code 0 (logical left) with distance n from 1 to 31 gives op_in shifted up by n with zeros in the low n bits. carry_out is op_in[32-n].
- R2: Kind code 1 (logical right) with distance n from 1 to 31 gives op_in shifted down by n with zeros in the top n bits. carry_out is op_in[n-1].
- R3: Kind code 2 (arithmetic right) with distance n from 1 to 31 gives op_in shifted down by n with the top n bits copied from op_in[31]. carry_out is op_in[n-1].
- R4: Kind code 3 (rotate right) with distance n from 1 to 31 moves each bit i of op_in to position (i-n) mod 32. carry_out is op_in[n-1], which equals the new op_out[31].
- R5: Kind code 4 (rotate through carry) gives {carry_in, op_in[31:1]} with carry_out = op_in[0]. The distance input has no effect for this kind, including a distance of 0.
- R6: For kind codes 0 to 3 with distance 0, op_out equals op_in and carry_out equals carry_in.
- R7: Kind codes 5, 6 and 7 pass op_in to op_out unchanged with carry_out = carry_in, for any distance.
- R8: For kind codes 0 to 3 with a nonzero distance, carry_in affects neither op_out nor carry_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_in | input | 32 | Second source operand before shifting |
| kind | input | 3 | Shift kind: 0 left, 1 right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| amount | input | 5 | Immediate shift distance |
| carry_in | input | 1 | Current carry flag |
| op_out | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry for the flag update |

## Verification
Two rules can apply in the same cycle: the zero-distance pass-through and the rotate through carry. When kind is 4 and the distance is 0, the rotate must still take place. The bench provokes this by running every distance in its sweep, 0 included, against every kind, with both carry values. Each result is judged against a reference model that builds the output one bit at a time from the requirements. In that model, kind 4 never reads the distance, so a design that lets the zero-distance bypass win is reported.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

    parameter int unsigned OPSH_DATA_W = 32;
    parameter int unsigned OPSH_KIND_W = 3;

    typedef enum logic [OPSH_KIND_W-1:0] {
        KIND_LSL = 3'd0,
        KIND_LSR = 3'd1,
        KIND_ASR = 3'd2,
        KIND_ROR = 3'd3,
        KIND_RRX = 3'd4
    } opsh_kind_e;

    // Control word produced by the decoder, consumed by the datapath.
    typedef struct packed {
        logic mirror;    // operate on the bit-reversed word (left shift)
        logic sign_fill; // vacated bits take the original top bit
        logic wrap;      // bits leaving the bottom re-enter at the top
        logic via_carry; // single step rotate through the carry flag
        logic pass;      // word and carry go through untouched
    } opsh_ctl_t;

    function automatic opsh_ctl_t opsh_decode_fn(input logic [OPSH_KIND_W-1:0] k,
                                                 input logic dist_zero);
        opsh_ctl_t c;
        c = '0;
        case (k)
            KIND_LSL: c.mirror    = 1'b1;
            KIND_LSR: c.mirror    = 1'b0;
            KIND_ASR: c.sign_fill = 1'b1;
            KIND_ROR: c.wrap      = 1'b1;
            KIND_RRX: c.via_carry = 1'b1;
            default:  c.pass      = 1'b1;
        endcase
        if (dist_zero && !c.via_carry) begin
            c.pass = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/opsh_decode.sv
module opsh_decode
    import opsh_pkg::*;
#(
    parameter int unsigned AMT_W = 5
) (
    input  logic [OPSH_KIND_W-1:0] kind,
    input  logic [AMT_W-1:0]       amount,
    output opsh_ctl_t              ctl
);
    logic dist_zero;

    assign dist_zero = (amount == '0);
    assign ctl       = opsh_decode_fn(kind, dist_zero);
endmodule

// File: rtl/opsh_bitrev.sv
module opsh_bitrev #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] flipped;

    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        assign flipped[i] = din[DATA_W-1-i];
    end

    assign dout = en ? flipped : din;
endmodule

// File: rtl/opsh_rshift_core.sv
// Logarithmic right shifter: one stage per distance bit, each stage
// either wraps the low bits to the top or fills with a constant bit.
module opsh_rshift_core #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amount,
    input  logic              wrap,
    input  logic              fill,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage [AMT_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        logic [DATA_W-1:0] moved;

        always_comb begin
            if (wrap) begin
                moved = {stage[k][STEP-1:0], stage[k][DATA_W-1:STEP]};
            end else begin
                moved = {{STEP{fill}}, stage[k][DATA_W-1:STEP]};
            end
        end

        assign stage[k+1] = amount[k] ? moved : stage[k];
    end

    assign dout = stage[AMT_W];
endmodule

// File: rtl/opsh_carry_pick.sv
// Last bit shifted out of a right shift by amount: bit amount-1 of the
// (possibly mirrored) input word. Only meaningful for a nonzero amount.
module opsh_carry_pick #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amount,
    output logic              cout
);
    logic [AMT_W-1:0] last_idx;

    assign last_idx = amount - {{(AMT_W-1){1'b0}}, 1'b1};
    assign cout     = din[last_idx];
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
    import opsh_pkg::*;
#(
    parameter int unsigned DATA_W = OPSH_DATA_W,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]      op_in,
    input  logic [OPSH_KIND_W-1:0] kind,
    input  logic [AMT_W-1:0]       amount,
    input  logic                   carry_in,
    output logic [DATA_W-1:0]      op_out,
    output logic                   carry_out
);
    opsh_ctl_t         ctl;
    logic [DATA_W-1:0] pre_word;
    logic [DATA_W-1:0] core_word;
    logic [DATA_W-1:0] post_word;
    logic              core_fill;
    logic              core_carry;

    opsh_decode #(.AMT_W(AMT_W)) u_decode (
        .kind   (kind),
        .amount (amount),
        .ctl    (ctl)
    );

    opsh_bitrev #(.DATA_W(DATA_W)) u_rev_in (
        .en   (ctl.mirror),
        .din  (op_in),
        .dout (pre_word)
    );

    assign core_fill = ctl.sign_fill & op_in[DATA_W-1];

    opsh_rshift_core #(.DATA_W(DATA_W)) u_core (
        .din    (pre_word),
        .amount (amount),
        .wrap   (ctl.wrap),
        .fill   (core_fill),
        .dout   (core_word)
    );

    opsh_bitrev #(.DATA_W(DATA_W)) u_rev_out (
        .en   (ctl.mirror),
        .din  (core_word),
        .dout (post_word)
    );

    opsh_carry_pick #(.DATA_W(DATA_W)) u_carry (
        .din    (pre_word),
        .amount (amount),
        .cout   (core_carry)
    );

    always_comb begin
        if (ctl.pass) begin
            op_out    = op_in;
            carry_out = carry_in;
        end else if (ctl.via_carry) begin
            op_out    = {carry_in, op_in[DATA_W-1:1]};
            carry_out = op_in[0];
        end else begin
            op_out    = post_word;
            carry_out = core_carry;
        end
    end
endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input logic [DATA_W-1:0] op_in,
    input logic [2:0]        kind,
    input logic [AMT_W-1:0]  amount,
    input logic              carry_in,
    input logic [DATA_W-1:0] op_out,
    input logic              carry_out
);
    logic [AMT_W-1:0]  neg_amt;
    logic [AMT_W-1:0]  dec_amt;
    logic [DATA_W-1:0] low_mask;
    logic              known;

    assign neg_amt  = '0 - amount;
    assign dec_amt  = amount - {{(AMT_W-1){1'b0}}, 1'b1};
    assign low_mask = ({{(DATA_W-1){1'b0}}, 1'b1} << amount) - {{(DATA_W-1){1'b0}}, 1'b1};
    assign known    = !$isunknown({op_in, kind, amount, carry_in, op_out, carry_out});

    always_comb begin
        if (known) begin
            if (kind == 3'd0 && amount != '0) begin
                AST_LSL_FILL: assert (((op_out & low_mask) == '0) && (carry_out == op_in[neg_amt]))
                    else $error("left shift fill or carry wrong"); // R1
            end
            if (kind == 3'd1 && amount != '0) begin
                AST_LSR_FILL: assert (((op_out >> neg_amt) == '0) && (carry_out == op_in[dec_amt]))
                    else $error("right shift fill or carry wrong"); // R2
            end
            if (kind == 3'd2 && amount != '0) begin
                AST_ASR_SIGN: assert ((op_out[DATA_W-1] == op_in[DATA_W-1]) && (carry_out == op_in[dec_amt]))
                    else $error("arithmetic shift sign or carry wrong"); // R3
            end
            if (kind == 3'd3 && amount != '0) begin
                AST_ROR_KEEP: assert (($countones(op_out) == $countones(op_in)) && (carry_out == op_out[DATA_W-1]))
                    else $error("rotate lost bits or carry wrong"); // R4
            end
            if (kind == 3'd4) begin
                AST_RRX_EDGE: assert ((op_out[DATA_W-1] == carry_in) && (carry_out == op_in[0]))
                    else $error("carry rotate wrong"); // R5
            end
            if (kind <= 3'd3 && amount == '0) begin
                AST_ZERO_PASS: assert ((op_out == op_in) && (carry_out == carry_in))
                    else $error("zero distance altered operand"); // R6
            end
            if (kind >= 3'd5) begin
                AST_BAD_CODE_PASS: assert ((op_out == op_in) && (carry_out == carry_in))
                    else $error("unused code altered operand"); // R7
            end
        end
    end
endmodule

bind operand_shifter operand_shifter_chk #(.DATA_W(DATA_W)) chk_i (
    .op_in     (op_in),
    .kind      (kind),
    .amount    (amount),
    .carry_in  (carry_in),
    .op_out    (op_out),
    .carry_out (carry_out)
);

// File: tb/operand_shifter_tb_top.sv
module operand_shifter_tb_top;

    typedef struct {
        logic [31:0] data;
        logic        cy;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_in = '0;
    logic [2:0]  kind = '0;
    logic [4:0]  amount = '0;
    logic        carry_in = 1'b0;
    logic [31:0] op_out;
    logic        carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_item_t sb_q[$];

    always #2 clk = ~clk; // 4 ns period

    operand_shifter dut_i (
        .op_in     (op_in),
        .kind      (kind),
        .amount    (amount),
        .carry_in  (carry_in),
        .op_out    (op_out),
        .carry_out (carry_out)
    );

    // Reference model built bit by bit from the requirements.
    function automatic exp_item_t model(input logic [31:0] a, input logic [2:0] k,
                                        input int n, input logic c);
        exp_item_t e;
        e.data = a;
        e.cy   = c;
        if (k == 3'd4) begin
            e.tag = "R5";
            e.data[31] = c;
            for (int i = 0; i < 31; i++) e.data[i] = a[i+1];
            e.cy = a[0];
        end else if (k >= 3'd5) begin
            e.tag = "R7";
        end else if (n == 0) begin
            e.tag = "R6";
        end else begin
            for (int i = 0; i < 32; i++) begin
                case (k)
                    3'd0: e.data[i] = (i >= n) ? a[i-n] : 1'b0;
                    3'd1: e.data[i] = (i + n < 32) ? a[i+n] : 1'b0;
                    3'd2: e.data[i] = (i + n < 32) ? a[i+n] : a[31];
                    default: e.data[i] = a[(i+n)%32];
                endcase
            end
            e.cy = (k == 3'd0) ? a[32-n] : a[n-1];
            if (c) e.tag = "R8";
            else case (k)
                3'd0: e.tag = "R1";
                3'd1: e.tag = "R2";
                3'd2: e.tag = "R3";
                default: e.tag = "R4";
            endcase
        end
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic [2:0] k,
                         input int n, input logic c);
        @(posedge clk);
        op_in    = a;
        kind     = k;
        amount   = 5'(n);
        carry_in = c;
        sb_q.push_back(model(a, k, n, c));
    endtask

    // Monitor: compare between edges.
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_item_t e;
            e = sb_q.pop_front();
            checks++;
            if (op_out !== e.data || carry_out !== e.cy) begin
                fails++;
                $display("FAIL %s: kind=%0d amt=%0d in=%h cin=%b out=%h/%b exp=%h/%b",
                         e.tag, kind, amount, op_in, carry_in, op_out, carry_out, e.data, e.cy);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [5] = '{32'h8000_0001, 32'hF0F0_1234, 32'h7FFF_FFFE,
                                   32'h0000_0000, 32'hFFFF_FFFF};
        int dists [6] = '{0, 1, 7, 16, 30, 31};
        repeat (3) @(posedge clk);
        // Quiet state: all-zero inputs give all-zero outputs (R6).
        @(negedge clk);
        checks++;
        if (op_out !== 32'h0 || carry_out !== 1'b0) begin
            fails++;
            $display("FAIL R6: quiet out=%h/%b exp=00000000/0", op_out, carry_out);
        end
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            for (int p = 0; p < 5; p++) begin
                for (int d = 0; d < 6; d++) begin
                    for (int c = 0; c < 2; c++) begin
                        drive(pats[p], 3'(k), dists[d], 1'(c));
                    end
                end
            end
        end
        // Walking single bit through every distance for each shift kind.
        for (int k = 0; k < 5; k++) begin
            for (int n = 0; n < 32; n++) begin
                drive(32'h0000_0001 << n, 3'(k), n, 1'(n & 1));
                drive(32'hA5C3_0F69, 3'(k), n, 1'(~n & 1));
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule